// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM that stores 36-bit words split into four 9-bit byte lanes. Address and control are registered on the rising clock edge. Data follows its address by a fixed two-cycle pipeline, and this lag is the same for reads and for writes. Read and write cycles can therefore be issued back to back in any mix, and the data bus never needs an idle turnaround cycle.

Each cycle either loads a new address and operation or advances an internal 2-bit burst counter. The counter walks a 4-word aligned block in either linear or interleaved order. Three enables qualify load cycles for depth expansion, and per-lane write enables mask the write. The block generates its output drive enable internally and in step with the clock. The bidirectional data bus appears as separate write-data, read-data and drive-enable signals. The array depth is a parameter.

Top module: `zbt_sram`

## Requirements
- R1: Address and control are captured on the rising edge of `clk_i` (edge k). For a read, `rdata_o` holds the word and `drive_o` is 1 from edge k+2 until edge k+3.
- R2: On a load cycle, `we_i`=1 selects a write and `we_i`=0 selects a read. There is no other strobe.
- R3: For a write captured at edge k, the data on `wdata_i` is sampled at edge k+2.
- R4: Reads and writes may follow each other on consecutive cycles in any order. A read issued in the cycle directly after a write to the same address returns the newly written data.
- R5: A cycle with `adv_i`=1 after a load steps the burst count n = 1, 2, 3, 0, and so on. With linear order, the accessed address is the load address with its low two bits replaced by (low bits + n) mod 4. The upper bits stay fixed.
- R6: With interleaved order, the low two bits are (load low bits XOR n). The order is taken from `order_i` (1 = interleaved, 0 = linear) on the load cycle only.
- R7: Advance cycles repeat the operation type of the burst's load cycle, and `we_i` is ignored on them.
- R8: `byte_we_i[j]` (active high) enables the write of bits 9j+8:9j. It is sampled in every cycle together with the address, advance cycles included. Disabled lanes keep their contents.
- R9: A load cycle with `en_i` != 3'b111 is a deselect. It performs no access, it ends any burst, and advance cycles after it perform no access until the next selected load.
- R10: `drive_o` is 1 only in the data phase of a read, and 0 in every other cycle.
- R11: While `rst_ni` is low, `drive_o` and `rdata_o` are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, used on load cycles |
| we_i | input | 1 | 1 = write, 0 = read (load cycles) |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| en_i | input | 3 | Chip enables, all must be 1 to select |
| byte_we_i | input | 4 | Per-lane write enables |
| order_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| wdata_i | input | 36 | Write data, two cycles after its address |
| rdata_o | output | 36 | Read data |
| drive_o | output | 1 | Output drive enable for the data bus |

## Verification
The main hazard arises when a write's data phase and a read's address phase share a cycle, and more generally when a write to an address is still inside the pipeline while a read of that same address enters it. The bench provokes this with long runs in which every write is followed at once by a read of the same address. Those runs are interleaved with bursts that advance across the wrap point in both orders. The bench keeps its own word array in program order, computes each read's expected word and `drive_o` value at issue time, and compares them in the data-phase cycle two edges later.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  // low two address bits of burst beat n
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              adv_i,
  input  logic [2:0]        en_i,
  input  logic [LANES-1:0]  byte_we_i,
  input  logic              order_i,
  output logic              op_vld_o,
  output logic              op_we_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [LANES-1:0]  op_bwe_o
);
  import zbt_pkg::*;

  logic              act_q, we_q, ord_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_n;
  logic              sel;

  assign sel      = &en_i;
  assign cnt_n    = cnt_q + 2'd1;
  assign op_bwe_o = byte_we_i;

  always_comb begin
    if (!adv_i) begin
      op_vld_o  = sel;
      op_we_o   = we_i;
      op_addr_o = addr_i;
    end else begin
      op_vld_o  = act_q;
      op_we_o   = we_q;
      op_addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_n, ord_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      we_q   <= 1'b0;
      ord_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!adv_i) begin
      act_q  <= sel;
      we_q   <= we_i;
      ord_q  <= order_i;
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (act_q) begin
      cnt_q  <= cnt_n;
    end
  end

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && act_q) |=> (act_q && cnt_q == $past(cnt_q) + 2'd1));
  assert_op_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ($stable(we_q) && $stable(ord_q) && $stable(base_q)));
  assert_desel_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !(&en_i)) |=> !act_q);
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bwe_i,
  output logic              vld_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bwe_o
);
  logic              vld_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bwe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      bwe_q  <= '0;
      vld_o  <= 1'b0;
      we_o   <= 1'b0;
      addr_o <= '0;
      bwe_o  <= '0;
    end else begin
      vld_q  <= vld_i;
      we_q   <= we_i;
      addr_q <= addr_i;
      bwe_q  <= bwe_i;
      vld_o  <= vld_q;
      we_o   <= we_q;
      addr_o <= addr_q;
      bwe_o  <= bwe_q;
    end
  end

  assert_lat_vld_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ##1 vld_o);
  assert_lat_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ##1 !vld_o);
  assert_lat_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ##1 (we_o == $past(we_i, 2)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bwe_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] old_w, new_w;
  logic              do_wr, do_rd;

  assign do_wr = vld_i && we_i;
  assign do_rd = vld_i && !we_i;
  assign old_w = mem[addr_i];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign new_w[j*LANE_W +: LANE_W] = bwe_i[j] ? wdata_i[j*LANE_W +: LANE_W]
                                                : old_w[j*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[addr_i] <= new_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      drive_o <= 1'b0;
    end else begin
      drive_o <= do_rd;
      if (do_rd) rdata_o <= old_w;
    end
  end

  assert_drive_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !we_i) |=> drive_o);
  assert_drive_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_i && !we_i) |=> !drive_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic                    adv_i,
  input  logic [2:0]              en_i,
  input  logic [LANES-1:0]        byte_we_i,
  input  logic                    order_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  logic              c_vld, c_we, p_vld, p_we;
  logic [ADDR_W-1:0] c_addr, p_addr;
  logic [LANES-1:0]  c_bwe, p_bwe;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .adv_i, .en_i, .byte_we_i, .order_i,
    .op_vld_o(c_vld), .op_we_o(c_we), .op_addr_o(c_addr), .op_bwe_o(c_bwe)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk_i, .rst_ni,
    .vld_i(c_vld), .we_i(c_we), .addr_i(c_addr), .bwe_i(c_bwe),
    .vld_o(p_vld), .we_o(p_we), .addr_o(p_addr), .bwe_o(p_bwe)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni,
    .vld_i(p_vld), .we_i(p_we), .addr_i(p_addr), .bwe_i(p_bwe),
    .wdata_i, .rdata_o, .drive_o
  );

  assert_rst_quiet_R11: assert property (@(posedge clk_i)
    !rst_ni |=> (!drive_o || rst_ni));
endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int NW    = 1 << AW;
  localparam int NS    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0, adv_i = 1'b0, order_i = 1'b0;
  logic [2:0]    en_i = 3'b000;
  logic [3:0]    byte_we_i = 4'hF;
  logic [35:0]   wdata_i = '0;
  logic [35:0]   rdata_o;
  logic          drive_o;

  zbt_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i, .we_i, .adv_i, .en_i, .byte_we_i,
    .order_i, .wdata_i, .rdata_o, .drive_o
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [35:0] model [NW];
  bit          s_rd  [NS];
  logic [35:0] s_exp [NS];
  logic [35:0] s_wd  [NS];
  string       s_tag [NS];
  string       cur_tag = "R1";

  logic [AW-1:0] mb_base = '0;
  logic [1:0]    mb_cnt = '0;
  bit            mb_act = 0, mb_we = 0, mb_ord = 0;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [35:0] pat(input int a, input int salt);
    return 36'(a * 36'h1_2345_6789 + salt * 36'h0_9E37_79B9) ^ 36'h9_5A5A_A5A5;
  endfunction

  // one bus cycle: check data phase of current edge, then drive next op
  task automatic op(input bit adv, input bit we, input int addr, input logic [2:0] en,
                    input logic [3:0] bwe, input bit ord, input logic [35:0] data);
    int i, k;
    bit acc, w;
    logic [AW-1:0] ea;
    logic [35:0] mask;
    @(negedge clk);
    i = cyc % NS;
    if (s_rd[i]) begin
      chk(drive_o === 1'b1, "R10 drive in read", 36'(drive_o), 36'd1);
      chk(rdata_o === s_exp[i], s_tag[i], rdata_o, s_exp[i]);
    end else begin
      chk(drive_o === 1'b0, "R10 drive idle", 36'(drive_o), 36'd0);
    end
    s_rd[i] = 0;
    wdata_i = s_wd[(cyc + 1) % NS];
    addr_i = AW'(addr); we_i = we; adv_i = adv; en_i = en;
    byte_we_i = bwe; order_i = ord;
    k = (cyc + 3) % NS;
    s_rd[k] = 0; s_wd[k] = '0;
    acc = 0; w = 0; ea = '0;
    if (!adv) begin
      mb_act = (en == 3'b111); mb_base = AW'(addr); mb_cnt = 0;
      mb_we = we; mb_ord = ord;
      acc = mb_act; w = we; ea = AW'(addr);
    end else if (mb_act) begin
      mb_cnt = mb_cnt + 2'd1;
      ea = {mb_base[AW-1:2], mb_ord ? (mb_base[1:0] ^ mb_cnt) : (mb_base[1:0] + mb_cnt)};
      acc = 1; w = mb_we;
    end
    if (acc) begin
      if (w) begin
        mask = {{9{bwe[3]}}, {9{bwe[2]}}, {9{bwe[1]}}, {9{bwe[0]}}};
        model[ea] = (model[ea] & ~mask) | (data & mask);
        s_wd[k] = data;
      end else begin
        s_rd[k] = 1; s_exp[k] = model[ea]; s_tag[k] = cur_tag;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) op(0, 0, 0, 3'b000, 4'hF, 0, '0);
  endtask

  initial begin
    for (int j = 0; j < NS; j++) begin s_rd[j] = 0; s_wd[j] = '0; s_exp[j] = '0; s_tag[j] = ""; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drive_o === 1'b0, "R11 reset drive", 36'(drive_o), 36'd0);
    chk(rdata_o === 36'd0, "R11 reset data", rdata_o, 36'd0);
    rst_n = 1'b1;
    // advance straight after reset: no burst active
    cur_tag = "R11";
    op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    op(1, 1, 0, 3'b111, 4'hF, 0, 36'h1);
    idle(3);

    // fill with linear write bursts
    cur_tag = "R1 R2 R3";
    for (int b = 0; b < NW; b += 4) begin
      op(0, 1, b, 3'b111, 4'hF, 0, pat(b, 0));
      for (int n = 1; n < 4; n++) op(1, 1, 0, 3'b111, 4'hF, 0, pat(b + n, 0));
    end
    // linear read bursts, every start offset, wrapping inside the block
    cur_tag = "R5 linear";
    for (int b = 0; b < NW; b += 4) begin
      op(0, 0, b + (b / 4) % 4, 3'b111, 4'hF, 0, '0);
      for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 1, '0);
    end
    // interleaved read bursts, order pin flipped on advances
    cur_tag = "R6 interleaved";
    for (int b = 0; b < NW; b += 4) begin
      op(0, 0, b + (b / 4 * 3) % 4, 3'b111, 4'hF, 1, '0);
      for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    end
    // back-to-back write/read, same address, no idle cycles
    cur_tag = "R4 turnaround";
    for (int j = 0; j < NW; j++) begin
      op(0, 1, (j * 7) % NW, 3'b111, 4'hF, 0, pat(j, 1));
      op(0, 0, (j * 7) % NW, 3'b111, 4'hF, 0, '0);
      op(0, 0, (j * 11) % NW, 3'b111, 4'hF, 0, '0);
    end
    // byte lanes, every mask
    cur_tag = "R8 lanes";
    for (int m = 0; m < 16; m++) begin
      op(0, 1, m, 3'b111, 4'(m), 0, ~pat(m, 2));
      op(0, 0, m, 3'b111, 4'hF, 0, '0);
    end
    // lane masks changing on advance beats
    op(0, 1, 40, 3'b111, 4'b0001, 0, pat(40, 3));
    op(1, 1, 0, 3'b111, 4'b0010, 0, pat(41, 3));
    op(1, 1, 0, 3'b111, 4'b0100, 0, pat(42, 3));
    op(1, 1, 0, 3'b111, 4'b1000, 0, pat(43, 3));
    op(0, 0, 40, 3'b111, 4'hF, 0, '0);
    for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    // advance keeps burst operation type
    cur_tag = "R7 keep read";
    op(0, 0, 8, 3'b111, 4'hF, 0, '0);
    for (int n = 1; n < 4; n++) op(1, 1, 0, 3'b111, 4'hF, 0, pat(99, n));
    cur_tag = "R7 keep write";
    op(0, 1, 22, 3'b111, 4'hF, 0, pat(22, 4));
    for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 0, pat(22 + n, 4));
    op(0, 0, 20, 3'b111, 4'hF, 0, '0);
    for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    // deselect: every partial enable pattern does nothing
    cur_tag = "R9 deselect";
    for (int e = 0; e < 7; e++) begin
      op(0, 1, 5, 3'(e), 4'hF, 0, pat(77, e));
      op(0, 0, 5, 3'(e), 4'hF, 0, '0);
      op(0, 0, 5, 3'b111, 4'hF, 0, '0);
    end
    // deselect mid-burst ends it
    op(0, 0, 12, 3'b111, 4'hF, 0, '0);
    op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    op(0, 1, 12, 3'b011, 4'hF, 0, pat(55, 5));
    op(1, 1, 0, 3'b111, 4'hF, 0, pat(56, 5));
    op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    op(0, 0, 12, 3'b111, 4'hF, 0, '0);
    for (int n = 1; n < 4; n++) op(1, 0, 0, 3'b111, 4'hF, 0, '0);
    idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule